// File: doc/BRIEF.md
# Packed Single-to-Half Float Converter

This block narrows a vector of IEEE-754 binary32 values into IEEE-754 binary16 values, one lane at a time, and returns them packed into a 128-bit word. A mode pin picks between four active lanes and eight active lanes. Each operation carries a 3-bit rounding selector. Four of its codes name a rounding rule directly. The remaining codes defer to a 2-bit rounding field that a separate control register supplies.

Every lane handles the full input range: normals, binary32 subnormals, signed zeros, infinities, quiet and signalling NaNs, values too large for binary16 and values too small for a binary16 normal. The packed result appears one clock after a valid input. Four exception flags gather into a sticky register that only reset clears.

Top module: `sp2hp_pack`

## Requirements
- R1: With `wide_mode`=0, lanes 0 to 3 are converted and `dst[127:64]` is zero. The inputs in lanes 4 to 7 change neither the result nor the flags.
- R2: With `wide_mode`=1, all eight lanes are converted. The result of lane i (input bits [32i+31:32i]) lands at `dst[16i+15:16i]`.
- R3: `rc_sel` codes 0, 1, 2 and 3 select these rules: 0 is nearest with ties to even, 1 is toward negative infinity, 2 is toward positive infinity, and 3 is toward zero.
- R4: `rc_sel` codes 4, 5, 6 and 7 all use the rule in `rc_field`, which is encoded like codes 0 to 3.
- R5: Exactly representable finite values, signed zeros and infinities convert with no flag raised.
- R6: A NaN becomes a binary16 NaN with the sign kept, the fraction taken from the top 10 input fraction bits, and the fraction MSB forced to 1. An input whose fraction MSB is 0 (signalling) raises invalid.
- R7: When a finite magnitude rounds above 65504, the result is infinity if the rule rounds away from zero for that sign (nearest, toward negative infinity for a negative value, toward positive infinity for a positive value). Otherwise the result is 0x7BFF with the sign. Overflow and inexact are raised in both cases.
- R8: A magnitude below 2^-14 before rounding is produced as a rounded binary16 subnormal, or as zero. Underflow is raised only when such a value is also inexact. A rounded-up carry may reach the smallest normal.
- R9: Inexact is raised when any discarded bit of an active lane is nonzero. The flags of all active lanes are ORed into `flags_sticky`, which never clears except on reset. The bit order is [0] inexact, [1] underflow, [2] overflow, [3] invalid.
- R10: `out_valid` is `in_valid` delayed by one clock. `dst` and `flags_sticky` take on the effect of an operation in that same cycle.
- R11: While `rst` is high at a clock edge, `out_valid`, `dst` and `flags_sticky` become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| wide_mode | input | 1 | 1 = eight lanes, 0 = four lanes |
| rc_sel | input | 3 | Rounding selector for this operation |
| rc_field | input | 2 | Rounding field from the control register |
| src | input | 256 | Eight packed binary32 lanes |
| out_valid | output | 1 | Result valid |
| dst | output | 128 | Packed binary16 results |
| flags_sticky | output | 4 | Sticky exception flags |

## Verification
Within one operation, the NaN path and the overflow path can run in different lanes, and their flags must merge in the same cycle. The bench provokes this by sending a signalling NaN and an oversized value in one eight-lane word. It then expects both converted lanes and the flag value 0xD. The bench also sends operations back to back, so that a new result and a sticky update land on consecutive edges. It sends a four-lane word with a signalling NaN and an oversized value in the ignored upper lanes, and expects no flag from them.

// File: rtl/sp2hp_pkg.sv
package sp2hp_pkg;

    localparam int SP_W = 32;
    localparam int HP_W = 16;
    localparam int EXP_SHIFT = 112;            // bias 127 minus bias 15
    localparam int MAX_RSH = 12;               // extra right shift beyond the fixed 13
    localparam logic [HP_W-1:0] HP_INF = 16'h7C00;
    localparam logic [HP_W-1:0] HP_MAXF = 16'h7BFF;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_FLOOR   = 2'd1,
        RM_CEIL    = 2'd2,
        RM_ZERO    = 2'd3
    } rmode_e;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } xflags_t;

    function automatic logic round_up(input rmode_e m, input logic neg,
                                      input logic lsb, input logic g, input logic st);
        case (m)
            RM_NEAREST: return g & (st | lsb);
            RM_FLOOR:   return (g | st) & neg;
            RM_CEIL:    return (g | st) & ~neg;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic ovf_saturates_inf(input rmode_e m, input logic neg);
        case (m)
            RM_NEAREST: return 1'b1;
            RM_FLOOR:   return neg;
            RM_CEIL:    return ~neg;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sp2hp_rsel.sv
module sp2hp_rsel
    import sp2hp_pkg::*;
(
    input  logic [2:0] sel,
    input  logic [1:0] field,
    output rmode_e     mode
);
    always_comb begin
        if (sel[2]) mode = rmode_e'(field);
        else        mode = rmode_e'(sel[1:0]);
    end
endmodule

// File: rtl/sp2hp_lane.sv
module sp2hp_lane
    import sp2hp_pkg::*;
(
    input  logic [SP_W-1:0] x,
    input  rmode_e          mode,
    output logic [HP_W-1:0] y,
    output xflags_t         fl
);
    logic              sgn;
    logic [7:0]        ex;
    logic [22:0]       fr;
    logic signed [9:0] hexp;
    logic [23:0]       mant;
    logic [3:0]        rsh;
    logic [35:0]       shv;
    logic [10:0]       kept;
    logic              grd, stk, inc, is_norm;
    logic [14:0]       base;
    logic [15:0]       sum;

    assign sgn = x[31];
    assign ex  = x[30:23];
    assign fr  = x[22:0];

    always_comb begin
        hexp    = $signed({2'b00, ex}) - 10'(EXP_SHIFT);
        mant    = (ex == 8'd0) ? {1'b0, fr} : {1'b1, fr};
        is_norm = (hexp >= 10'sd1);
        if (is_norm)                    rsh = 4'd0;
        else if (hexp <= -10'sd12)      rsh = 4'(MAX_RSH);
        else                            rsh = 4'(10'sd1 - hexp);
        shv  = {mant, 12'b0} >> rsh;
        kept = shv[35:25];
        grd  = shv[24];
        stk  = |shv[23:0];
        base = is_norm ? {hexp[4:0], kept[9:0]} : {5'b0, kept[9:0]};
        inc  = round_up(mode, sgn, kept[0], grd, stk);
        sum  = {1'b0, base} + {15'b0, inc};

        y  = {sgn, sum[14:0]};
        fl = '0;
        if (ex == 8'hFF) begin
            if (fr == 23'd0) begin
                y = {sgn, HP_INF[14:0]};
            end else begin
                y = {sgn, 5'h1F, 1'b1, fr[21:13]};
                fl.invalid = ~fr[22];
            end
        end else if (ex == 8'd0 && fr == 23'd0) begin
            y = {sgn, 15'd0};
        end else if (hexp >= 10'sd31 || sum >= {1'b0, HP_INF[14:0]}) begin
            y = ovf_saturates_inf(mode, sgn) ? {sgn, HP_INF[14:0]} : {sgn, HP_MAXF[14:0]};
            fl.overflow = 1'b1;
            fl.inexact  = 1'b1;
        end else begin
            fl.inexact   = grd | stk;
            fl.underflow = ~is_norm & (grd | stk);
        end
    end
endmodule

// File: rtl/sp2hp_pack.sv
module sp2hp_pack
    import sp2hp_pkg::*;
#(
    parameter int LANES = 8,
    localparam int SRC_W = LANES * SP_W,
    localparam int DST_W = LANES * HP_W,
    localparam int NARROW = LANES / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             wide_mode,
    input  logic [2:0]       rc_sel,
    input  logic [1:0]       rc_field,
    input  logic [SRC_W-1:0] src,
    output logic             out_valid,
    output logic [DST_W-1:0] dst,
    output logic [3:0]       flags_sticky
);
    rmode_e            mode;
    logic [LANES-1:0]  act;
    logic [HP_W-1:0]   lane_y  [LANES];
    xflags_t           lane_fl [LANES];
    logic [DST_W-1:0]  res;
    xflags_t           merged;

    sp2hp_rsel u_rsel (.sel(rc_sel), .field(rc_field), .mode(mode));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign act[i] = wide_mode || (i < NARROW);

        sp2hp_lane u_lane (
            .x    (src[SP_W*i +: SP_W]),
            .mode (mode),
            .y    (lane_y[i]),
            .fl   (lane_fl[i])
        );

        assign res[HP_W*i +: HP_W] = act[i] ? lane_y[i] : '0;

        // R6
        nan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && act[i] && src[SP_W*i+30 -: 8] == 8'hFF && src[SP_W*i+22 -: 23] != 23'd0)
            |=> (dst[HP_W*i+14 -: 6] == 6'h3F));

        // R7
        no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && act[i] && lane_fl[i].overflow)
            |=> (dst[HP_W*i+14 -: 15] == HP_INF[14:0] || dst[HP_W*i+14 -: 15] == HP_MAXF[14:0]));
    end

    always_comb begin
        merged = '0;
        for (int i = 0; i < LANES; i++)
            if (act[i]) merged = merged | lane_fl[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            dst          <= '0;
            flags_sticky <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst          <= res;
                flags_sticky <= flags_sticky | merged;
            end
        end
    end

    // R10
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R1
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_mode) |=> (dst[DST_W-1:DST_W/2] == '0));

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(flags_sticky) & ~flags_sticky) == 4'b0));

endmodule

// File: tb/test_sp2hp_pack.sv
module test_sp2hp_pack;

    typedef struct {
        logic [127:0] d;
        logic [3:0]   f;
        string        req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         wide_mode = 1'b0;
    logic [2:0]   rc_sel = 3'd0;
    logic [1:0]   rc_field = 2'd0;
    logic [255:0] src = '0;
    logic         out_valid;
    logic [127:0] dst;
    logic [3:0]   flags_sticky;

    int checks = 0;
    int fails = 0;
    logic [3:0] exp_sticky = 4'd0;
    item_t sb[$];

    localparam logic [31:0] ONE = 32'h3F800000;

    always #10 clk = ~clk;

    sp2hp_pack i_sp2hp_pack (
        .clk(clk), .rst(rst), .in_valid(in_valid), .wide_mode(wide_mode),
        .rc_sel(rc_sel), .rc_field(rc_field), .src(src),
        .out_valid(out_valid), .dst(dst), .flags_sticky(flags_sticky)
    );

    task automatic send(input logic w, input logic [2:0] sel, input logic [1:0] fld,
                        input logic [255:0] s, input logic [127:0] e,
                        input logic [3:0] f, input string req);
        item_t it;
        @(negedge clk);
        in_valid  = 1'b1;
        wide_mode = w;
        rc_sel    = sel;
        rc_field  = fld;
        src       = s;
        exp_sticky = exp_sticky | f;
        it.d = e; it.f = exp_sticky; it.req = req;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src = '1;
        end
    endtask

    task automatic do_reset();
        idle(2);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || dst !== '0 || flags_sticky !== 4'd0) begin
            fails++;
            $display("FAIL R11 reset state: valid=%b dst=%h flags=%h expected 0/0/0",
                     out_valid, dst, flags_sticky);
        end
        rst = 1'b0;
        exp_sticky = 4'd0;
    endtask

    // monitor: samples 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R10 unexpected out_valid: actual 1 expected 0");
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    checks += 2;
                    if (dst !== it.d) begin
                        fails++;
                        $display("FAIL %s dst: actual %h expected %h", it.req, dst, it.d);
                    end
                    if (flags_sticky !== it.f) begin
                        fails++;
                        $display("FAIL %s flags: actual %h expected %h", it.req, flags_sticky, it.f);
                    end
                end
            end else if (sb.size() != 0) begin
                checks++; fails++;
                $display("FAIL R10 out_valid: actual 0 expected 1");
            end
        end
    end

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();

        // R2 R5: exact values, eight lanes
        send(1'b1, 3'd0, 2'd0,
             {32'h477FE000, 32'hFF800000, 32'h7F800000, 32'h80000000,
              32'h00000000, 32'h3F000000, 32'hC0000000, ONE},
             {16'h7BFF, 16'hFC00, 16'h7C00, 16'h8000, 16'h0000, 16'h3800, 16'hC000, 16'h3C00},
             4'h0, "R2/R5");
        // R1: four lanes, upper lanes carry sNaN and oversized values that must be ignored
        send(1'b0, 3'd0, 2'd0,
             {32'h7FA00000, 32'h47C35000, 32'h7FA00000, 32'h47C35000,
              32'h38800000, 32'hC0000000, 32'h3F000000, ONE},
             {64'h0, 16'h0400, 16'hC000, 16'h3800, 16'h3C00},
             4'h0, "R1");
        idle(1);
        // R10: no result after an idle cycle
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R10 idle: actual %b expected 0", out_valid);
        end

        // R3: direct rounding codes, back to back
        do_reset();
        send(1'b1, 3'd0, 2'd3,
             {{5{ONE}}, 32'hBF801000, 32'h3F803000, 32'h3F801000},
             {{5{16'h3C00}}, 16'hBC00, 16'h3C02, 16'h3C00}, 4'h1, "R3 nearest");
        send(1'b1, 3'd1, 2'd2,
             {{5{ONE}}, 32'hBF801000, 32'h3F803000, 32'h3F801000},
             {{5{16'h3C00}}, 16'hBC01, 16'h3C01, 16'h3C00}, 4'h1, "R3 floor");
        send(1'b1, 3'd2, 2'd1,
             {{5{ONE}}, 32'hBF801000, 32'h3F803000, 32'h3F801000},
             {{5{16'h3C00}}, 16'hBC00, 16'h3C02, 16'h3C01}, 4'h1, "R3 ceil");
        send(1'b1, 3'd3, 2'd0,
             {{5{ONE}}, 32'hBF801000, 32'h3F803000, 32'h3F801000},
             {{5{16'h3C00}}, 16'hBC00, 16'h3C01, 16'h3C00}, 4'h1, "R3 zero");
        // R4: deferred codes use rc_field
        send(1'b1, 3'd4, 2'd2,
             {{5{ONE}}, 32'hBF801000, 32'h3F803000, 32'h3F801000},
             {{5{16'h3C00}}, 16'hBC00, 16'h3C02, 16'h3C01}, 4'h1, "R4 code4");
        send(1'b1, 3'd6, 2'd1,
             {{5{ONE}}, 32'hBF801000, 32'h3F803000, 32'h3F801000},
             {{5{16'h3C00}}, 16'hBC01, 16'h3C01, 16'h3C00}, 4'h1, "R4 code6");
        send(1'b1, 3'd7, 2'd3,
             {{5{ONE}}, 32'hBF801000, 32'h3F803000, 32'h3F801000},
             {{5{16'h3C00}}, 16'hBC00, 16'h3C01, 16'h3C00}, 4'h1, "R4 code7");

        // R6: quiet NaNs raise nothing, signalling raises invalid
        do_reset();
        send(1'b0, 3'd0, 2'd0,
             {{4{32'h0}}, ONE, ONE, 32'hFFC00000, 32'h7FC00000},
             {64'h0, 16'h3C00, 16'h3C00, 16'hFE00, 16'h7E00}, 4'h0, "R6 quiet");
        send(1'b0, 3'd0, 2'd0,
             {{4{32'h0}}, ONE, 32'hFFC00001, 32'h7FA00000, 32'h7FC00000},
             {64'h0, 16'h3C00, 16'hFE00, 16'h7F00, 16'h7E00}, 4'h8, "R6 signalling");

        // R7: overflow under each rule
        do_reset();
        send(1'b1, 3'd0, 2'd0,
             {{5{ONE}}, 32'hC7C35000, 32'h47C35000, 32'h477FF000},
             {{5{16'h3C00}}, 16'hFC00, 16'h7C00, 16'h7C00}, 4'h5, "R7 nearest");
        send(1'b1, 3'd3, 2'd0,
             {{5{ONE}}, 32'hC7C35000, 32'h47C35000, 32'h477FF000},
             {{5{16'h3C00}}, 16'hFBFF, 16'h7BFF, 16'h7BFF}, 4'h5, "R7 zero");
        send(1'b1, 3'd1, 2'd0,
             {{5{ONE}}, 32'hC7C35000, 32'h47C35000, 32'h477FF000},
             {{5{16'h3C00}}, 16'hFC00, 16'h7BFF, 16'h7BFF}, 4'h5, "R7 floor");
        send(1'b1, 3'd2, 2'd0,
             {{5{ONE}}, 32'hC7C35000, 32'h47C35000, 32'h477FF000},
             {{5{16'h3C00}}, 16'hFBFF, 16'h7C00, 16'h7C00}, 4'h5, "R7 ceil");

        // R8 R9: exact subnormal raises nothing, then tiny inexact values
        do_reset();
        send(1'b1, 3'd0, 2'd0,
             {{7{ONE}}, 32'h33800000},
             {{7{16'h3C00}}, 16'h0001}, 4'h0, "R8 exact subnormal");
        send(1'b1, 3'd0, 2'd0,
             {{4{ONE}}, 32'h80000001, 32'h00000001, 32'h387FF000, 32'h33000000},
             {{4{16'h3C00}}, 16'h8000, 16'h0000, 16'h0400, 16'h0000}, 4'h3, "R8 nearest");
        send(1'b1, 3'd2, 2'd0,
             {{4{ONE}}, 32'h80000001, 32'h00000001, 32'h387FF000, 32'h33000000},
             {{4{16'h3C00}}, 16'h8000, 16'h0001, 16'h0400, 16'h0001}, 4'h3, "R8 ceil");
        send(1'b1, 3'd1, 2'd0,
             {{4{ONE}}, 32'h80000001, 32'h00000001, 32'h387FF000, 32'h33000000},
             {{4{16'h3C00}}, 16'h8001, 16'h0000, 16'h03FF, 16'h0000}, 4'h3, "R8 floor");
        // R9: exact operation leaves sticky flags set
        send(1'b1, 3'd0, 2'd0, {8{ONE}}, {8{16'h3C00}}, 4'h0, "R9 sticky hold");

        // R9: NaN and overflow lanes in one operation merge their flags
        do_reset();
        send(1'b1, 3'd0, 2'd0,
             {{6{ONE}}, 32'h47C35000, 32'h7FA00000},
             {{6{16'h3C00}}, 16'h7C00, 16'h7F00}, 4'hD, "R9 merged");

        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule